// File: doc/BRIEF.md
# MII Transmit Jabber Guard

This block sits between a MAC and the line side of a nibble-wide MII transmit path. It counts how long transmit enable stays high without a break. When a transmission runs past a configurable limit, the block enters a jabber state. In that state it silences the line transmit outputs and the loopback outputs, and it raises a collision indication toward the MAC.

The block leaves the jabber state on its own. This happens only after transmit enable has stayed low for a fixed release interval. Any new transmit activity during that interval restarts the countdown. A control input switches the whole guard off, and the data paths then simply follow the MAC. A status output reports the jabber state to a management register.

At a 25 MHz clock the defaults give a limit of 20 ms and a release delay of 500 ms. That delay lies inside the required 250 ms to 750 ms window. Both values are parameters, so simulation can use small ones.

Top module: `mii_jabber_guard`

## Requirements
- R1: With the guard enabled, transmit enable held high for LIMIT consecutive clock cycles does not start jabber. If it is still high in cycle LIMIT+1, jabber_active is 1 from the following cycle.
- R2: While jabber_active is 1, phy_tx_en, phy_txd, lb_rx_dv and lb_rxd are all 0 in the same cycle, whatever the MAC drives.
- R3: col_out is 1 in exactly the cycles where jabber_active is 1.
- R4: Jabber clears once mac_tx_en has been low for RELEASE consecutive cycles. jabber_active is still 1 during the RELEASE-th low cycle and is 0 from the next cycle.
- R5: A cycle with mac_tx_en high during the release countdown restarts it, so a further RELEASE low cycles are needed after that high cycle.
- R6: Outside jabber, one low cycle of mac_tx_en clears the run length. LIMIT high cycles, one low cycle and then LIMIT high cycles again never start jabber.
- R7: With guard_off at 1, jabber never starts, col_out and jabber_active are 0, and the paths follow the MAC. Raising guard_off while in jabber reopens the paths and drops col_out in that same cycle, and the jabber state is gone once guard_off returns to 0.
- R8: Outside jabber, with lb_mode at 0, phy_tx_en follows mac_tx_en in the same cycle, and lb_rx_dv and lb_rxd are 0. With lb_mode at 1, lb_rx_dv follows mac_tx_en, and phy_tx_en and phy_txd are 0. On each path the data output equals mac_txd when that path's enable output is 1, and is 0 otherwise.
- R9: While rst_n is low and just after reset, jabber_active and col_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_off | input | 1 | Control bit: 1 disables the jabber guard |
| lb_mode | input | 1 | 1 routes MAC transmit to the loopback path instead of the line |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| phy_tx_en | output | 1 | Gated transmit enable toward the line |
| phy_txd | output | 4 | Gated transmit nibble toward the line |
| lb_rx_dv | output | 1 | Gated data valid on the loopback receive path |
| lb_rxd | output | 4 | Gated nibble on the loopback receive path |
| col_out | output | 1 | Collision indication, high during jabber |
| jabber_active | output | 1 | Jabber status for a management register |

## Verification
Two things can land in the same cycle: the cycle in which the run-length limit would be crossed, and a rise of guard_off. The bench holds transmit enable high for LIMIT cycles and then raises guard_off exactly in cycle LIMIT+1. It judges the result by checking that jabber_active stays 0 in the following cycle and that the line path keeps passing data. The bench also raises guard_off while jabber is active with transmit still high, and checks that the paths reopen in that very cycle.

// File: rtl/jg_pkg.sv
package jg_pkg;

    // Number of gated output paths: line transmit and loopback receive.
    localparam int unsigned NPATH = 2;
    localparam int unsigned PATH_LINE = 0;
    localparam int unsigned PATH_LOOP = 1;

    typedef struct packed {
        logic jab;
    } guard_state_t;

endpackage

// File: rtl/jg_span_counter.sv
module jg_span_counter #(
    parameter int unsigned MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);

    localparam int unsigned W = (MAX < 1) ? 1 : $clog2(MAX + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } span_t;

    span_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (inc && (s_q.cnt != W'(MAX))) begin
            s_d.cnt = s_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit = (s_q.cnt == W'(MAX));

endmodule

// File: rtl/jg_path_gate.sv
module jg_path_gate #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              sel,
    input  logic              blk,
    input  logic              en_in,
    input  logic [DATA_W-1:0] d_in,
    output logic              en_out,
    output logic [DATA_W-1:0] d_out
);

    logic pass;

    always_comb begin
        pass   = sel && !blk && en_in;
        en_out = pass;
        d_out  = pass ? d_in : '0;
    end

endmodule

// File: rtl/mii_jabber_guard.sv
module mii_jabber_guard
    import jg_pkg::*;
#(
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned LIMIT   = 500_000,
    parameter int unsigned RELEASE = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_off,
    input  logic              lb_mode,
    input  logic              mac_tx_en,
    input  logic [DATA_W-1:0] mac_txd,
    output logic              phy_tx_en,
    output logic [DATA_W-1:0] phy_txd,
    output logic              lb_rx_dv,
    output logic [DATA_W-1:0] lb_rxd,
    output logic              col_out,
    output logic              jabber_active
);

    localparam int unsigned REL_MAX = (RELEASE < 1) ? 0 : RELEASE - 1;

    guard_state_t st_d, st_q;
    logic dur_clr, dur_hit;
    logic rel_clr, rel_hit;
    logic blk;

    // Run-length timer: counts consecutive high cycles outside jabber.
    assign dur_clr = guard_off || !mac_tx_en || st_q.jab;
    jg_span_counter #(.MAX(LIMIT)) u_dur (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dur_clr),
        .inc   (mac_tx_en),
        .hit   (dur_hit)
    );

    // Release timer: counts consecutive quiet cycles while in jabber.
    assign rel_clr = guard_off || !st_q.jab || mac_tx_en;
    jg_span_counter #(.MAX(REL_MAX)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rel_clr),
        .inc   (!mac_tx_en),
        .hit   (rel_hit)
    );

    always_comb begin
        st_d = st_q;
        if (guard_off) begin
            st_d.jab = 1'b0;
        end else if (!st_q.jab) begin
            if (mac_tx_en && dur_hit) begin
                st_d.jab = 1'b1;
            end
        end else if (!mac_tx_en && rel_hit) begin
            st_d.jab = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk = st_q.jab && !guard_off;

    // Two gated paths built from one gate cell.
    logic              p_en [NPATH];
    logic [DATA_W-1:0] p_d  [NPATH];

    for (genvar gi = 0; gi < NPATH; gi++) begin : g_path
        jg_path_gate #(.DATA_W(DATA_W)) u_gate (
            .sel    ((gi == PATH_LOOP) ? lb_mode : !lb_mode),
            .blk    (blk),
            .en_in  (mac_tx_en),
            .d_in   (mac_txd),
            .en_out (p_en[gi]),
            .d_out  (p_d[gi])
        );
    end

    assign phy_tx_en     = p_en[PATH_LINE];
    assign phy_txd       = p_d[PATH_LINE];
    assign lb_rx_dv      = p_en[PATH_LOOP];
    assign lb_rxd        = p_d[PATH_LOOP];
    assign col_out       = blk;
    assign jabber_active = blk;

    // Entry happens only on a cycle where transmit was high at the limit.
    assert_entry_on_long_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.jab) |-> $past(mac_tx_en) && $past(dur_hit));

    // Both data paths are silent whenever the block is jabbering.
    assert_paths_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blk |-> !p_en[PATH_LINE] && !p_en[PATH_LOOP]
                && (p_d[PATH_LINE] == '0) && (p_d[PATH_LOOP] == '0));

    // Collision is never raised while any path carries data.
    assert_col_no_traffic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_out |-> !phy_tx_en && !lb_rx_dv);

    // Exit without guard_off only after a full quiet release interval.
    assert_exit_after_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.jab) && !$past(guard_off)) |-> !$past(mac_tx_en) && $past(rel_hit));

    // Turning the guard off clears the jabber state at the next edge.
    assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        guard_off |=> !st_q.jab);

endmodule

// File: tb/tb_mii_jabber_guard.sv
module tb_mii_jabber_guard;

    localparam int unsigned LIM = 8;
    localparam int unsigned REL = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       guard_off = 1'b0;
    logic       lb_mode = 1'b0;
    logic       mac_tx_en = 1'b0;
    logic [3:0] mac_txd = 4'h0;
    logic       phy_tx_en, lb_rx_dv, col_out, jabber_active;
    logic [3:0] phy_txd, lb_rxd;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mii_jabber_guard #(.DATA_W(4), .LIMIT(LIM), .RELEASE(REL)) dut (
        .clk(clk), .rst_n(rst_n), .guard_off(guard_off), .lb_mode(lb_mode),
        .mac_tx_en(mac_tx_en), .mac_txd(mac_txd),
        .phy_tx_en(phy_tx_en), .phy_txd(phy_txd),
        .lb_rx_dv(lb_rx_dv), .lb_rxd(lb_rxd),
        .col_out(col_out), .jabber_active(jabber_active)
    );

    // {off, lb, en, txd} -> {phy_en, phy_d, lb_dv, lb_d}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 4'h5, 1'b1, 4'h5, 1'b0, 4'h0},
        {1'b0, 1'b0, 1'b1, 4'hA, 1'b1, 4'hA, 1'b0, 4'h0},
        {1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 4'h0, 1'b0, 4'h0},
        {1'b0, 1'b1, 1'b1, 4'h3, 1'b0, 4'h0, 1'b1, 4'h3},
        {1'b0, 1'b1, 1'b0, 4'h7, 1'b0, 4'h0, 1'b0, 4'h0},
        {1'b1, 1'b0, 1'b1, 4'hC, 1'b1, 4'hC, 1'b0, 4'h0},
        {1'b1, 1'b1, 1'b1, 4'h9, 1'b0, 4'h0, 1'b1, 4'h9},
        {1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, then settle before the rising edge.
    task automatic tick(input logic off, input logic lb, input logic en, input logic [3:0] d);
        @(negedge clk);
        guard_off = off;
        lb_mode   = lb;
        mac_tx_en = en;
        mac_txd   = d;
        #2;
    endtask

    task automatic enter_jabber();
        for (int k = 0; k < int'(LIM) + 1; k++) tick(1'b0, 1'b0, 1'b1, 4'h6);
        tick(1'b0, 1'b0, 1'b1, 4'h6);
    endtask

    initial begin
        #1;
        chk("R9 status in reset", jabber_active, 0);
        chk("R9 col in reset", col_out, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R9 status after reset", jabber_active, 0);

        // R8 table walk
        for (int i = 0; i < 8; i++) begin
            tick(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:10]);
            chk("R8 phy_tx_en", phy_tx_en, int'(VEC[i][9]));
            chk("R8 phy_txd", phy_txd, int'(VEC[i][8:5]));
            chk("R8 lb_rx_dv", lb_rx_dv, int'(VEC[i][4]));
            chk("R8 lb_rxd", lb_rxd, int'(VEC[i][3:0]));
            chk("R3 col idle", col_out, 0);
        end

        // R1 limit boundary
        for (int k = 0; k < int'(LIM) + 1; k++) begin
            tick(1'b0, 1'b0, 1'b1, 4'hB);
            chk("R1 no jabber up to limit", jabber_active, 0);
            chk("R8 line passes", phy_txd, 4'hB);
        end
        tick(1'b0, 1'b0, 1'b1, 4'hB);
        chk("R1 jabber after limit", jabber_active, 1);
        chk("R2 line en blocked", phy_tx_en, 0);
        chk("R2 line data blocked", phy_txd, 0);
        chk("R3 col during jabber", col_out, 1);
        tick(1'b0, 1'b1, 1'b1, 4'hD);
        chk("R2 loop dv blocked", lb_rx_dv, 0);
        chk("R2 loop data blocked", lb_rxd, 0);

        // R4 release timing
        for (int k = 0; k < int'(REL); k++) begin
            tick(1'b0, 1'b0, 1'b0, 4'h0);
            chk("R4 held during release", jabber_active, 1);
        end
        tick(1'b0, 1'b0, 1'b0, 4'h0);
        chk("R4 released", jabber_active, 0);
        chk("R3 col released", col_out, 0);

        // R5 restart of the release countdown
        enter_jabber();
        chk("R5 jabber entered", jabber_active, 1);
        repeat (5) tick(1'b0, 1'b0, 1'b0, 4'h0);
        tick(1'b0, 1'b0, 1'b1, 4'h2);
        chk("R2 blocked on re-rise", phy_tx_en, 0);
        for (int k = 0; k < int'(REL); k++) begin
            tick(1'b0, 1'b0, 1'b0, 4'h0);
            chk("R5 countdown restarted", jabber_active, 1);
        end
        tick(1'b0, 1'b0, 1'b0, 4'h0);
        chk("R5 released after restart", jabber_active, 0);

        // R6 one low cycle clears the run length
        for (int k = 0; k < int'(LIM); k++) tick(1'b0, 1'b0, 1'b1, 4'h4);
        tick(1'b0, 1'b0, 1'b0, 4'h0);
        for (int k = 0; k < int'(LIM); k++) tick(1'b0, 1'b0, 1'b1, 4'h4);
        tick(1'b0, 1'b0, 1'b0, 4'h0);
        tick(1'b0, 1'b0, 1'b0, 4'h0);
        chk("R6 no jabber across gap", jabber_active, 0);

        // R7 long run with the guard off
        for (int k = 0; k < 3 * int'(LIM); k++) tick(1'b1, 1'b0, 1'b1, 4'h8);
        chk("R7 off: no jabber", jabber_active, 0);
        chk("R7 off: col low", col_out, 0);
        chk("R7 off: line passes", phy_txd, 4'h8);
        tick(1'b0, 1'b0, 1'b0, 4'h0);

        // R7 guard_off rises in the cycle the limit would be crossed
        for (int k = 0; k < int'(LIM); k++) tick(1'b0, 1'b0, 1'b1, 4'h1);
        tick(1'b1, 1'b0, 1'b1, 4'h1);
        chk("R7 coincident off passes", phy_tx_en, 1);
        tick(1'b0, 1'b0, 1'b1, 4'h1);
        chk("R7 coincident off no jabber", jabber_active, 0);
        tick(1'b0, 1'b0, 1'b0, 4'h0);

        // R7 guard_off raised during jabber
        enter_jabber();
        chk("R7 jabber before off", jabber_active, 1);
        tick(1'b1, 1'b0, 1'b1, 4'hE);
        chk("R7 off reopens line", phy_tx_en, 1);
        chk("R7 off reopens data", phy_txd, 4'hE);
        chk("R7 off drops col", col_out, 0);
        tick(1'b1, 1'b0, 1'b0, 4'h0);
        tick(1'b0, 1'b0, 1'b0, 4'h0);
        chk("R7 jabber gone after off", jabber_active, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule